// File: doc/BRIEF.md
# Five-Channel Double-Buffered PWM Timer

This peripheral holds five independent down-counting timers, each driving one pulse-width-modulated output pin. Software reaches it through a flat 32-bit register bus: a write strobe, a byte address whose two low bits are ignored, write data, and a read-data return that follows the address combinationally. Each channel has a period buffer and a threshold buffer. Neither value reaches the running counter until software asks for a manual load or the counter wraps with reload enabled, so a new waveform always takes effect on a period boundary.

A channel counts down by one on every clock while its run bit is set. At zero it either reloads both working values from the buffers or parks at zero. Its pin is high when the live count is at or below the working threshold, and a per-channel polarity bit flips it. A sticky status word records each channel reaching zero; software clears it by writing ones. Two configuration words are plain storage. A dead-band enable bit is kept for channel 0 but has no effect here.

Top module: `pwm_bank`

## Requirements
- R1: While reset is asserted and after it is released, every readable register reads 0, every live count is 0, and every output pin is high.
- R2: Byte offsets 0x00 and 0x04 store and return full 32-bit words. The period buffer of channel n is at 0x0C+12n and its threshold buffer at 0x10+12n; both return the low 16 written bits, zero-extended. Unmapped offsets read 0.
- R3: The control word at 0x08 gives channel n a field starting at bit 0 for n=0 and at bit 4(n+1) otherwise. Inside a field: +0 run, +1 load, +2 invert, +3 reload. Bit 4 is the dead-band enable of channel 0. Only these bits are stored, so the word reads back masked by 0x00FFFF1F.
- R4: While a channel's load bit is set, its live count and threshold are copied from the buffers on every clock and no counting takes place. The live count reads at 0x14+12n.
- R5: With run set and load clear, a nonzero live count falls by one per clock.
- R6: With run and reload set, a live count of zero is replaced on the next clock by the period buffer, and the threshold by the threshold buffer, giving a period of buffer+1 clocks.
- R7: With run set and reload clear, a channel that reaches zero stays at zero.
- R8: With run and load both clear, the live count holds.
- R9: Output n is high when live count ≤ working threshold and low otherwise, inverted when the invert bit is set.
- R10: Status bit n (offset 0x44) sets on each clock in which channel n, running, is given a zero count by decrement or reload. Writing 1 to a bit clears it; a new event in the same clock wins.
- R11: Offset 0x44 returns the status word, which shadows channel 4's live-count slot.
- R12: Buffer writes made while a channel runs leave its live count untouched until the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; counting advances once per edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current offset |
| pwm_out | output | 5 | One waveform pin per channel |

## Verification
Directed runs on one channel separate manual load from counting, a wrap with reload from a park at zero, and a stopped channel from a running one. A buffer rewrite in mid-period shows whether the new value waits for the wrap. Random phases mix short periods, random thresholds and polarity, and status clears landing on event clocks, so a wrong compare direction, a wrong reload clock or a lost status set all show up against the bench's cycle model. Bit-layout probes on channel 3 and the channel-4/status overlap check the field positions and the decode priority.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

  localparam int unsigned OFF_CFG0    = 32'h00;
  localparam int unsigned OFF_CFG1    = 32'h04;
  localparam int unsigned OFF_CTRL    = 32'h08;
  localparam int unsigned OFF_STAT    = 32'h44;
  localparam int unsigned OFF_CH_BASE = 32'h0C;
  localparam int unsigned CH_STRIDE   = 12;
  localparam int unsigned SLOT_CNTB   = 0;
  localparam int unsigned SLOT_CMPB   = 4;
  localparam int unsigned SLOT_OBS    = 8;

  localparam int unsigned F_RUN  = 0;
  localparam int unsigned F_LOAD = 1;
  localparam int unsigned F_INV  = 2;
  localparam int unsigned F_AR   = 3;
  localparam int unsigned F_DZ   = 4;

  function automatic int unsigned ctl_pos(int unsigned n);
    return (n == 0) ? 0 : (n + 1) * 4;
  endfunction

  function automatic logic [31:0] ctl_mask(int unsigned nch);
    logic [31:0] m;
    m = 32'h0;
    for (int unsigned n = 0; n < nch; n++) begin
      for (int unsigned b = 0; b < 4; b++) begin
        m[ctl_pos(n) + b] = 1'b1;
      end
    end
    m[F_DZ] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs
  import pwm_bank_pkg::*;
#(
  parameter int unsigned NCH = 5,
  parameter int unsigned CW  = 16,
  parameter int unsigned AW  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [AW-1:0]           addr,
  input  logic [31:0]             wdata,
  input  logic [NCH-1:0][CW-1:0]  obs,
  input  logic [NCH-1:0]          ev,
  output logic [31:0]             rdata,
  output logic [NCH-1:0][CW-1:0]  cntb,
  output logic [NCH-1:0][CW-1:0]  cmpb,
  output logic [NCH-1:0]          run,
  output logic [NCH-1:0]          load,
  output logic [NCH-1:0]          inv,
  output logic [NCH-1:0]          ar
);

  localparam logic [31:0] CTL_MASK = ctl_mask(NCH);

  logic [AW-1:0] addr_w;
  wire           unused_lo = ^addr[1:0];

  logic [31:0]            cfg0_q, cfg1_q, ctrl_q;
  logic [NCH-1:0]         stat_q, stat_d;
  logic                   cfg0_en, cfg1_en, ctrl_en;
  logic [NCH-1:0]         cntb_en, cmpb_en;
  logic [NCH-1:0][CW-1:0] cntb_q, cmpb_q;

  assign addr_w = {addr[AW-1:2], 2'b00};

  // write decode
  always_comb begin
    cfg0_en = we && (addr_w == AW'(OFF_CFG0));
    cfg1_en = we && (addr_w == AW'(OFF_CFG1));
    ctrl_en = we && (addr_w == AW'(OFF_CTRL));
    for (int unsigned n = 0; n < NCH; n++) begin
      cntb_en[n] = we && (addr_w == AW'(OFF_CH_BASE + CH_STRIDE * n + SLOT_CNTB));
      cmpb_en[n] = we && (addr_w == AW'(OFF_CH_BASE + CH_STRIDE * n + SLOT_CMPB));
    end
    if (we && (addr_w == AW'(OFF_STAT))) begin
      stat_d = (stat_q & ~wdata[NCH-1:0]) | ev;
    end else begin
      stat_d = stat_q | ev;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg0_q <= '0;
      cfg1_q <= '0;
      ctrl_q <= '0;
      stat_q <= '0;
    end else begin
      if (cfg0_en) cfg0_q <= wdata;
      if (cfg1_en) cfg1_q <= wdata;
      if (ctrl_en) ctrl_q <= wdata & CTL_MASK;
      stat_q <= stat_d;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_buf
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cntb_q[g] <= '0;
        cmpb_q[g] <= '0;
      end else begin
        if (cntb_en[g]) cntb_q[g] <= wdata[CW-1:0];
        if (cmpb_en[g]) cmpb_q[g] <= wdata[CW-1:0];
      end
    end
    assign run[g]  = ctrl_q[ctl_pos(g) + F_RUN];
    assign load[g] = ctrl_q[ctl_pos(g) + F_LOAD];
    assign inv[g]  = ctrl_q[ctl_pos(g) + F_INV];
    assign ar[g]   = ctrl_q[ctl_pos(g) + F_AR];
  end

  assign cntb = cntb_q;
  assign cmpb = cmpb_q;

  // read mux; later matches take priority, so status shadows any channel slot
  always_comb begin
    rdata = '0;
    if (addr_w == AW'(OFF_CFG0)) rdata = cfg0_q;
    if (addr_w == AW'(OFF_CFG1)) rdata = cfg1_q;
    if (addr_w == AW'(OFF_CTRL)) rdata = ctrl_q;
    for (int unsigned n = 0; n < NCH; n++) begin
      if (addr_w == AW'(OFF_CH_BASE + CH_STRIDE * n + SLOT_CNTB)) rdata = 32'(cntb_q[n]);
      if (addr_w == AW'(OFF_CH_BASE + CH_STRIDE * n + SLOT_CMPB)) rdata = 32'(cmpb_q[n]);
      if (addr_w == AW'(OFF_CH_BASE + CH_STRIDE * n + SLOT_OBS))  rdata = 32'(obs[n]);
    end
    if (addr_w == AW'(OFF_STAT)) rdata = 32'(stat_q);
  end

endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          load,
  input  logic          inv,
  input  logic          ar,
  input  logic [CW-1:0] cntb,
  input  logic [CW-1:0] cmpb,
  output logic [CW-1:0] cnt,
  output logic          ev,
  output logic          pwm
);

  logic [CW-1:0] cnt_q, cnt_d, cmp_q, cmp_d;
  logic          cnt_en, cmp_en, at_zero;

  assign at_zero = (cnt_q == '0);

  always_comb begin
    cnt_d  = cnt_q;
    cmp_d  = cmp_q;
    cnt_en = 1'b0;
    cmp_en = 1'b0;
    if (load) begin
      cnt_d  = cntb;
      cmp_d  = cmpb;
      cnt_en = 1'b1;
      cmp_en = 1'b1;
    end else if (run) begin
      if (!at_zero) begin
        cnt_d  = cnt_q - 1'b1;
        cnt_en = 1'b1;
      end else if (ar) begin
        cnt_d  = cntb;
        cmp_d  = cmpb;
        cnt_en = 1'b1;
        cmp_en = 1'b1;
      end
    end
    ev = run && !load && (cnt_d == '0) && (!at_zero || ar);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cmp_q <= '0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      if (cmp_en) cmp_q <= cmp_d;
    end
  end

  assign cnt = cnt_q;
  assign pwm = (cnt_q <= cmp_q) ^ inv;

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank #(
  parameter int unsigned NCH = 5,
  parameter int unsigned CW  = 16,
  parameter int unsigned AW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_we,
  input  logic [AW-1:0]  bus_addr,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  output logic [NCH-1:0] pwm_out
);

  logic [1:0]             rs_q;
  logic                   rst_sync_n;
  logic [NCH-1:0][CW-1:0] buf_cnt, buf_cmp, ch_cnt;
  logic [NCH-1:0]         ch_run, ch_load, ch_inv, ch_ar, ch_ev;

  // assert asynchronously, release on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  pwm_bank_regs #(.NCH(NCH), .CW(CW), .AW(AW)) u_regs (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we    (bus_we),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .obs   (ch_cnt),
    .ev    (ch_ev),
    .rdata (bus_rdata),
    .cntb  (buf_cnt),
    .cmpb  (buf_cmp),
    .run   (ch_run),
    .load  (ch_load),
    .inv   (ch_inv),
    .ar    (ch_ar)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pwm_bank_chan #(.CW(CW)) u_chan (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .run   (ch_run[g]),
      .load  (ch_load[g]),
      .inv   (ch_inv[g]),
      .ar    (ch_ar[g]),
      .cntb  (buf_cnt[g]),
      .cmpb  (buf_cmp[g]),
      .cnt   (ch_cnt[g]),
      .ev    (ch_ev[g]),
      .pwm   (pwm_out[g])
    );
  end

endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
  parameter int unsigned NCH = 5,
  parameter int unsigned CW  = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NCH-1:0]         run,
  input logic [NCH-1:0]         load,
  input logic [NCH-1:0]         ar,
  input logic [NCH-1:0][CW-1:0] cntb,
  input logic [NCH-1:0][CW-1:0] cnt
);

  for (genvar g = 0; g < NCH; g++) begin : g_a
    a_r4_load_copies: assert property (@(posedge clk) disable iff (!rst_n)
      load[g] |=> (cnt[g] == $past(cntb[g])));

    a_r5_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
      (run[g] && !load[g] && (cnt[g] != '0)) |=> (cnt[g] == $past(cnt[g]) - 1'b1));

    a_r6_wrap_reloads: assert property (@(posedge clk) disable iff (!rst_n)
      (run[g] && !load[g] && ar[g] && (cnt[g] == '0)) |=> (cnt[g] == $past(cntb[g])));

    a_r7_parks_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (run[g] && !load[g] && !ar[g] && (cnt[g] == '0)) |=> (cnt[g] == '0));

    a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!run[g] && !load[g]) |=> $stable(cnt[g]));
  end

endmodule

bind pwm_bank pwm_bank_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk   (clk),
  .rst_n (rst_sync_n),
  .run   (ch_run),
  .load  (ch_load),
  .ar    (ch_ar),
  .cntb  (buf_cnt),
  .cnt   (ch_cnt)
);

// File: tb/sim_pwm_bank.sv
module sim_pwm_bank;

  localparam logic [31:0] MASK = 32'h00FF_FF1F;

  logic        clk = 1'b0;
  logic        rst_n, we;
  logic [7:0]  addr;
  logic [31:0] wdata, rdata;
  logic [4:0]  pwm_out;

  always #5 clk = ~clk;

  pwm_bank u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (we),
    .bus_addr  (addr),
    .bus_wdata (wdata),
    .bus_rdata (rdata),
    .pwm_out   (pwm_out)
  );

  int checks = 0;
  int fails  = 0;
  bit pchk   = 1'b0;
  bit done   = 1'b0;
  int cyc    = 0;

  // cycle model built from the requirements
  logic [15:0] m_cnt [5];
  logic [15:0] m_cmp [5];
  logic [15:0] m_cntb[5];
  logic [15:0] m_cmpb[5];
  logic [31:0] m_cfg0, m_cfg1, m_ctrl;
  logic [4:0]  m_stat, t_ev;
  logic [15:0] t_cnt, t_cmp;
  logic        t_r, t_l, t_a;

  function automatic int pos(int n);
    return (n == 0) ? 0 : (n + 1) * 4;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 0; n < 5; n++) begin
        m_cnt[n] = 0; m_cmp[n] = 0; m_cntb[n] = 0; m_cmpb[n] = 0;
      end
      m_cfg0 = 0; m_cfg1 = 0; m_ctrl = 0; m_stat = 0;
    end else begin
      t_ev = 0;
      for (int n = 0; n < 5; n++) begin
        t_r = m_ctrl[pos(n)]; t_l = m_ctrl[pos(n)+1]; t_a = m_ctrl[pos(n)+3];
        t_cnt = m_cnt[n]; t_cmp = m_cmp[n];
        if (t_l) begin
          t_cnt = m_cntb[n]; t_cmp = m_cmpb[n];
        end else if (t_r) begin
          if (m_cnt[n] != 0) t_cnt = m_cnt[n] - 1;
          else if (t_a) begin t_cnt = m_cntb[n]; t_cmp = m_cmpb[n]; end
        end
        if (t_r && !t_l && t_cnt == 0 && (m_cnt[n] != 0 || t_a)) t_ev[n] = 1'b1;
        m_cnt[n] = t_cnt; m_cmp[n] = t_cmp;
      end
      if (we && addr == 8'h44) m_stat = (m_stat & ~wdata[4:0]) | t_ev;
      else                     m_stat = m_stat | t_ev;
      if (we) begin
        if (addr == 8'h00) m_cfg0 = wdata;
        if (addr == 8'h04) m_cfg1 = wdata;
        if (addr == 8'h08) m_ctrl = wdata & MASK;
        for (int n = 0; n < 5; n++) begin
          if (addr == 8'(12 + 12*n)) m_cntb[n] = wdata[15:0];
          if (addr == 8'(16 + 12*n)) m_cmpb[n] = wdata[15:0];
        end
      end
    end
  end

  function automatic logic [31:0] rexp(logic [7:0] a);
    logic [31:0] r;
    r = 0;
    if (a == 8'h00) r = m_cfg0;
    if (a == 8'h04) r = m_cfg1;
    if (a == 8'h08) r = m_ctrl;
    for (int n = 0; n < 5; n++) begin
      if (a == 8'(12 + 12*n)) r = {16'h0, m_cntb[n]};
      if (a == 8'(16 + 12*n)) r = {16'h0, m_cmpb[n]};
      if (a == 8'(20 + 12*n)) r = {16'h0, m_cnt[n]};
    end
    if (a == 8'h44) r = {27'h0, m_stat};
    return r;
  endfunction

  function automatic logic [4:0] mpwm();
    logic [4:0] p;
    for (int n = 0; n < 5; n++) p[n] = (m_cnt[n] <= m_cmp[n]) ^ m_ctrl[pos(n)+2];
    return p;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rdchk(string tag, logic [7:0] a, logic [31:0] exp);
    addr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic tick(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic wait_zero(logic [7:0] a);
    logic [31:0] v;
    for (int i = 0; i < 40; i++) begin
      rd(a, v);
      if (v == 0) break;
      tick(1);
    end
  endtask

  // output compared against the model every cycle
  always @(negedge clk) begin
    if (pchk) chk("R9 pwm", {27'h0, pwm_out}, {27'h0, mpwm()});
  end

  function automatic logic [7:0] rand_addr();
    return 8'((($urandom % 20)) * 4);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc == 60000 && !done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, 60000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, d, c;
    logic [7:0]  a;
    void'($urandom(32'd1234));
    rst_n = 1'b0; we = 1'b0; addr = 0; wdata = 0;
    tick(3);
    for (int i = 0; i < 18; i++) rdchk("R1 reset read", 8'(i*4), 32'h0);
    chk("R1 reset pins", {27'h0, pwm_out}, 32'h1F);
    rst_n = 1'b1;
    tick(4);
    rdchk("R1 after release", 8'h20, 32'h0);
    chk("R1 pins after release", {27'h0, pwm_out}, 32'h1F);
    pchk = 1'b1;

    // R2 storage and decode
    wr(8'h00, 32'hDEAD_BEEF); rdchk("R2 cfg0", 8'h00, 32'hDEAD_BEEF);
    wr(8'h04, 32'h0123_4567); rdchk("R2 cfg1", 8'h04, 32'h0123_4567);
    wr(8'h0C, 32'hABCD_1234); rdchk("R2 period buffer", 8'h0C, 32'h0000_1234);
    wr(8'h28, 32'h5555_00A5); rdchk("R2 threshold buffer", 8'h28, 32'h0000_00A5);
    rdchk("R2 unmapped", 8'h48, 32'h0);
    rdchk("R2 unmapped high", 8'h80, 32'h0);

    // R3 control layout
    wr(8'h08, 32'hFFFF_FFFF); rdchk("R3 mask", 8'h08, MASK);
    wr(8'h08, 32'h0);
    wr(8'h30, 32'h77);
    wr(8'h08, 32'h1 << 17);
    tick(1);
    rdchk("R3 channel 3 field", 8'h38, 32'h77);
    rdchk("R3 channel 2 untouched", 8'h2C, rexp(8'h2C));
    wr(8'h08, 32'h0);

    // channel 1 directed
    wr(8'h18, 32'd5); wr(8'h1C, 32'd2);
    wr(8'h08, 32'h1 << 9);
    tick(1);
    rdchk("R4 manual load", 8'h20, 32'd5);
    tick(2);
    rdchk("R4 load holds", 8'h20, 32'd5);
    wr(8'h08, (32'h1 << 8) | (32'h1 << 11));
    tick(1);
    rdchk("R5 first decrement", 8'h20, 32'd4);
    chk("R9 above threshold", {31'h0, pwm_out[1]}, 32'h0);
    tick(1);
    rdchk("R5 second decrement", 8'h20, 32'd3);
    wait_zero(8'h20);
    tick(1);
    rdchk("R6 wrap reload", 8'h20, 32'd5);
    wr(8'h18, 32'd9);
    rd(8'h20, v);
    chk("R12 no early take", {31'h0, (v <= 5)}, 32'h1);
    wait_zero(8'h20);
    tick(1);
    rdchk("R12 taken at wrap", 8'h20, 32'd9);
    rd(8'h44, v);
    chk("R10 status set", {31'h0, v[1]}, 32'h1);

    // R7 stop reloading
    wr(8'h08, 32'h1 << 8);
    wait_zero(8'h20);
    tick(3);
    rdchk("R7 parked", 8'h20, 32'd0);
    rdchk("R10 status before clear", 8'h44, 32'h2);
    wr(8'h44, 32'h2);
    rdchk("R10 cleared", 8'h44, 32'h0);

    // R8 idle hold
    wr(8'h18, 32'd7);
    wr(8'h08, 32'h1 << 9);
    wr(8'h08, 32'h0);
    rdchk("R8 loaded", 8'h20, 32'd7);
    tick(5);
    rdchk("R8 holds", 8'h20, 32'd7);
    chk("R9 low above threshold", {31'h0, pwm_out[1]}, 32'h0);
    wr(8'h08, 32'h1 << 10);
    chk("R9 inverted", {31'h0, pwm_out[1]}, 32'h1);

    // R11 status shadows channel 4 count slot
    wr(8'h3C, 32'd3); wr(8'h40, 32'd1);
    wr(8'h08, 32'h1 << 21);
    tick(1);
    rdchk("R11 status wins", 8'h44, 32'h0);
    rdchk("R11 threshold buffer", 8'h40, 32'd1);
    chk("R11 pin shows count", {31'h0, pwm_out[4]}, 32'h0);
    wr(8'h08, 32'h0);

    // random phase
    for (int i = 0; i < 800; i++) begin
      c = $urandom % 8;
      if (c < 3) begin
        a = 8'(12 + 4 * ($urandom % 14));
        if (a == 8'h14 || a == 8'h20 || a == 8'h2C || a == 8'h38) a = a - 8'h4;
        wr(a, $urandom % 16);
      end else if (c == 3) begin
        d = $urandom & MASK;
        if (($urandom % 4) != 0) d = d & ~32'h0022_2222;
        wr(8'h08, d);
      end else if (c == 4) begin
        wr(8'h44, $urandom);
      end else begin
        a = rand_addr();
        rdchk("R6 random read", a, rexp(a));
        tick(1 + ($urandom % 3));
      end
    end
    rdchk("R10 final status", 8'h44, rexp(8'h44));

    pchk = 1'b0;
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule